// File: doc/BRIEF.md
# MAC address hash filter table engine

This block owns a 2048-entry table of 48-bit station addresses held in a local RAM and serves one command at a time: add an address with two attribute bits (skip and rd), delete an address, look an address up, or wipe the whole table. Each address is reduced to an 11-bit home index by a bit-reversing, XOR-folding hash. Collisions are resolved by linear probing: the engine walks forward from the home index one slot per clock, wrapping from the last slot to slot 0, for at most `HOP_LIMIT` slots.

A client raises `cmd_valid` for one cycle while `busy` is low. The engine then holds `busy` high until it pulses `done` for a single cycle. At that pulse the response outputs report whether a matching entry was found, whether an add ran out of probe slots, the last slot examined, and the entry words involved. The response stays valid until the next command is accepted.

The controller is a five-state machine. IDLE accepts a command: a clear goes to CLEAR, any other command goes to FETCH. FETCH issues the read of the home slot and always moves to PROBE. PROBE examines one slot per cycle. It stays in PROBE to step to the next slot, or moves to FINISH on a match, on a free slot, or on the last permitted hop. CLEAR writes zero to one slot per cycle and moves to FINISH after the last slot. FINISH pulses `done` and returns to IDLE.

Top module: `mac_hash_filter`

## Requirements
- R1: While reset is asserted, and on its release, `busy`, `done`, `rsp_hit` and `rsp_full` are 0, and `rsp_index`, `rsp_lo` and `rsp_hi` are zero.
- R2: The home index is computed in five steps. First, bits 7..0 of each of the six address bytes are reversed. The most significant byte is `cmd_mac[47:40]`. Second, L is the reversed low four bytes (`cmd_mac[31:0]`) and h is the reversed bit 0 of byte `cmd_mac[39:32]`, which equals `cmd_mac[39]`. Third, f0 = L[7:2], f1 = {L[14:8], L[1:0]}, f2 = L[23:15] and f3 = {h, L[31:24]}. Fourth, the index is the low 11 bits of (f0 << 9) | (f1 ^ f2 ^ f3). Fifth, an add into an empty table reports this index in `rsp_index`.
- R3: Probing starts at the home index and advances by one slot per hop, so addresses that share a home index occupy consecutive slots in insertion order.
- R4: The slot after 0x7FF is 0x000.
- R5: An add stops at the first slot that is either invalid or holds the same address, ignoring entry bits 2:0. It writes the new entry there and reports `rsp_hit`=1 when the address was already present. A re-add therefore replaces the skip and rd attributes in place.
- R6: If an add examines `HOP_LIMIT` (default 12) slots that are all valid and all different, it reports `rsp_full`=1, `rsp_hit`=0, `rsp_index` equal to the last slot examined, and writes nothing.
- R7: A delete that finds the address writes zero to both entry words and reports `rsp_hit`=1. A delete that reaches a free slot or the hop limit first reports `rsp_hit`=0 and `rsp_full`=0 and leaves the table unchanged.
- R8: A lookup never writes. It stops at a match (`rsp_hit`=1, `rsp_lo`/`rsp_hi` = the stored entry), at a free slot, or at the hop limit (`rsp_hit`=0, entry outputs zero). An entry placed beyond a slot that was later deleted is therefore no longer found.
- R9: The entry format is fixed. The low word holds, from bit 31 down: `cmd_mac[20]`, `[19:16]`, `[31:28]`, `[27:24]`, `[39:36]`, `[35:32]`, `[47:44]`, `[43:40]`, then rd at bit 2, skip at bit 1 and valid (1) at bit 0. The high word holds zero in bits 31:19, then `cmd_mac[7:4]`, `[3:0]`, `[15:12]`, `[11:8]`, `[23:21]` in bits 18:0. An add reports the written entry on `rsp_lo`/`rsp_hi`.
- R10: The command encoding is `cmd_op` = 0 lookup, 1 add, 2 delete, 3 clear-all. A clear-all makes every slot invalid, keeps `busy` high for exactly 2049 cycles, and reports all-zero responses.
- R11: `done` is high for exactly one cycle, and `busy` is low in the following cycle. `cmd_valid` is ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, taken only while busy is low |
| cmd_op | input | 2 | 0 lookup, 1 add, 2 delete, 3 clear-all |
| cmd_mac | input | 48 | Station address, byte 0 in bits 47:40 |
| cmd_skip | input | 1 | Skip attribute stored by an add |
| cmd_rd | input | 1 | rd attribute stored by an add |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| rsp_hit | output | 1 | Matching entry found |
| rsp_full | output | 1 | Add found no usable slot within the hop limit |
| rsp_index | output | 11 | Last slot examined |
| rsp_lo | output | 32 | Low entry word (stored on lookup hit, written on add) |
| rsp_hi | output | 32 | High entry word |

## Verification
A mis-stepped probe index or a wrong hash bit shows up at the very next `done`: `rsp_index` differs from the slot the reference model predicts. A corrupted or missing table write stays hidden until a later lookup, delete or re-add of that address, or of a colliding address behind it, reports the wrong hit, slot or entry words. A stuck state shows up as `busy` not falling within the expected cycle count. The clear path is checked by its exact busy span and by lookups that miss afterwards.

// File: rtl/mhf_pkg.sv
package mhf_pkg;
    localparam int unsigned IDX_W  = 11;
    localparam int unsigned DEPTH  = 1 << IDX_W;
    localparam int unsigned WORD_W = 32;

    localparam int unsigned VALID_BIT = 0;
    localparam int unsigned SKIP_BIT  = 1;
    localparam int unsigned RD_BIT    = 2;
    localparam int unsigned CTRL_W    = 3;

    typedef enum logic [1:0] {
        OP_LOOKUP = 2'd0,
        OP_ADD    = 2'd1,
        OP_DELETE = 2'd2,
        OP_CLEAR  = 2'd3
    } op_e;

    typedef struct packed {
        logic [WORD_W-1:0] hi;
        logic [WORD_W-1:0] lo;
    } entry_t;

    localparam int unsigned ENTRY_W = 2 * WORD_W;
endpackage

// File: rtl/mhf_hash.sv
module mhf_hash
    import mhf_pkg::*;
(
    input  logic [31:0]      low_part,
    input  logic             high_bit7,
    output logic [IDX_W-1:0] home_idx
);
    localparam int unsigned NBYTES = 4;

    logic [31:0] lrev;
    logic [5:0]  f0;
    logic [8:0]  f1;
    logic [8:0]  f2;
    logic [8:0]  f3;
    logic [8:0]  fold;

    // reverse the bit order inside every byte of the low part
    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        for (genvar k = 0; k < 8; k++) begin : g_bit
            assign lrev[8*b + k] = low_part[8*b + 7 - k];
        end
    end

    always_comb begin
        f0       = lrev[7:2];
        f1       = {lrev[14:8], lrev[1:0]};
        f2       = lrev[23:15];
        // reversed bit 0 of the lower high byte is its original bit 7
        f3       = {high_bit7, lrev[31:24]};
        fold     = f1 ^ f2 ^ f3;
        home_idx = IDX_W'(({f0, 9'd0}) | {6'd0, fold});
    end
endmodule

// File: rtl/mhf_encode.sv
module mhf_encode
    import mhf_pkg::*;
(
    input  logic [47:0] mac,
    input  logic        skip,
    input  logic        rd,
    output entry_t      entry
);
    logic [15:0] hpart;
    logic [31:0] lpart;

    always_comb begin
        hpart = mac[47:32];
        lpart = mac[31:0];

        entry.lo          = '0;
        entry.lo[31]      = lpart[20];
        entry.lo[30:27]   = lpart[19:16];
        entry.lo[26:23]   = lpart[31:28];
        entry.lo[22:19]   = lpart[27:24];
        entry.lo[18:15]   = hpart[7:4];
        entry.lo[14:11]   = hpart[3:0];
        entry.lo[10:7]    = hpart[15:12];
        entry.lo[6:3]     = hpart[11:8];
        entry.lo[RD_BIT]    = rd;
        entry.lo[SKIP_BIT]  = skip;
        entry.lo[VALID_BIT] = 1'b1;

        entry.hi          = '0;
        entry.hi[18:15]   = lpart[7:4];
        entry.hi[14:11]   = lpart[3:0];
        entry.hi[10:7]    = lpart[15:12];
        entry.hi[6:3]     = lpart[11:8];
        entry.hi[2:0]     = lpart[23:21];
    end
endmodule

// File: rtl/mhf_ram.sv
module mhf_ram #(
    parameter int unsigned AW = 11,
    parameter int unsigned DW = 64
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int unsigned NWORDS = 1 << AW;

    logic [DW-1:0] store [NWORDS];

    always_ff @(posedge clk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
        rdata <= store[raddr];
    end
endmodule

// File: rtl/mhf_probe_ctrl.sv
module mhf_probe_ctrl
    import mhf_pkg::*;
#(
    parameter int unsigned HOP_LIMIT = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_op,
    input  logic [IDX_W-1:0] key_idx,
    input  entry_t           key_entry,
    input  entry_t           rd_entry,
    output logic [IDX_W-1:0] ram_raddr,
    output logic             ram_we,
    output logic [IDX_W-1:0] ram_waddr,
    output entry_t           ram_wdata,
    output logic             busy,
    output logic             done,
    output logic             rsp_hit,
    output logic             rsp_full,
    output logic [IDX_W-1:0] rsp_index,
    output entry_t           rsp_entry
);
    localparam int unsigned HOP_W = $clog2(HOP_LIMIT + 1);

    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH,
        S_PROBE,
        S_CLEAR,
        S_FINISH
    } state_e;

    state_e           state_q, state_d;
    op_e              op_q;
    entry_t           key_q;
    logic [IDX_W-1:0] idx_q;
    logic [HOP_W-1:0] hop_q;
    logic [IDX_W-1:0] clr_q;

    logic             slot_free;
    logic             slot_match;
    logic             last_hop;
    logic             probe_stop;
    logic             clr_last;
    logic             accept;
    logic             add_slot;

    // slot evaluation against the entry read for idx_q
    always_comb begin
        slot_free  = !rd_entry.lo[VALID_BIT];
        slot_match = rd_entry.lo[VALID_BIT]
                   && (rd_entry.lo[WORD_W-1:CTRL_W] == key_q.lo[WORD_W-1:CTRL_W])
                   && (rd_entry.hi == key_q.hi);
        last_hop   = (hop_q == HOP_W'(HOP_LIMIT - 1));
        probe_stop = slot_free || slot_match || last_hop;
        clr_last   = (clr_q == {IDX_W{1'b1}});
        accept     = (state_q == S_IDLE) && cmd_valid;
        add_slot   = (op_q == OP_ADD) && (slot_free || slot_match);
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (cmd_valid) begin
                    state_d = (op_e'(cmd_op) == OP_CLEAR) ? S_CLEAR : S_FETCH;
                end
            end
            S_FETCH:  state_d = S_PROBE;
            S_PROBE:  if (probe_stop) state_d = S_FINISH;
            S_CLEAR:  if (clr_last) state_d = S_FINISH;
            S_FINISH: state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs: RAM control and handshake
    always_comb begin
        ram_raddr = (state_q == S_PROBE) ? idx_q + IDX_W'(1) : idx_q;
        ram_we    = 1'b0;
        ram_waddr = idx_q;
        ram_wdata = '0;
        busy      = (state_q != S_IDLE);
        done      = (state_q == S_FINISH);
        unique case (state_q)
            S_PROBE: begin
                if (add_slot) begin
                    ram_we    = 1'b1;
                    ram_wdata = key_q;
                end else if ((op_q == OP_DELETE) && slot_match) begin
                    ram_we    = 1'b1;
                end
            end
            S_CLEAR: begin
                ram_we    = 1'b1;
                ram_waddr = clr_q;
            end
            default: ;
        endcase
    end

    // command context and probe walk
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q  <= OP_LOOKUP;
            key_q <= '0;
            idx_q <= '0;
            hop_q <= '0;
            clr_q <= '0;
        end else if (accept) begin
            op_q  <= op_e'(cmd_op);
            key_q <= key_entry;
            idx_q <= key_idx;
            hop_q <= '0;
            clr_q <= '0;
        end else if ((state_q == S_PROBE) && !probe_stop) begin
            idx_q <= idx_q + IDX_W'(1);
            hop_q <= hop_q + HOP_W'(1);
        end else if (state_q == S_CLEAR) begin
            clr_q <= clr_q + IDX_W'(1);
        end
    end

    // response registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_hit   <= 1'b0;
            rsp_full  <= 1'b0;
            rsp_index <= '0;
            rsp_entry <= '0;
        end else if (accept) begin
            rsp_hit   <= 1'b0;
            rsp_full  <= 1'b0;
            rsp_index <= '0;
            rsp_entry <= '0;
        end else if ((state_q == S_PROBE) && probe_stop) begin
            rsp_hit   <= slot_match;
            rsp_full  <= (op_q == OP_ADD) && !slot_match && !slot_free;
            rsp_index <= idx_q;
            if ((op_q == OP_LOOKUP) && slot_match) begin
                rsp_entry <= rd_entry;
            end else if (add_slot) begin
                rsp_entry <= key_q;
            end else begin
                rsp_entry <= '0;
            end
        end
    end

    // R3 and R4: a continuing probe steps to the next slot, modulo table size
    assert_probe_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_PROBE && !probe_stop)
        |=> (state_q == S_PROBE && idx_q == $past(idx_q) + IDX_W'(1)));

    assert_hop_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_PROBE) |-> (hop_q < HOP_W'(HOP_LIMIT)));

    assert_full_only_add_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_full |-> (op_q == OP_ADD));

    assert_lookup_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_PROBE && op_q == OP_LOOKUP) |-> !ram_we);

    assert_clear_span_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_CLEAR && !clr_last) |=> (state_q == S_CLEAR));

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    assert_busy_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    assert_ignore_when_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> $stable(op_q));
endmodule

// File: rtl/mac_hash_filter.sv
module mac_hash_filter
    import mhf_pkg::*;
#(
    parameter int unsigned HOP_LIMIT = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_op,
    input  logic [47:0]      cmd_mac,
    input  logic             cmd_skip,
    input  logic             cmd_rd,
    output logic             busy,
    output logic             done,
    output logic             rsp_hit,
    output logic             rsp_full,
    output logic [IDX_W-1:0] rsp_index,
    output logic [31:0]      rsp_lo,
    output logic [31:0]      rsp_hi
);
    logic [IDX_W-1:0] home_idx;
    entry_t           key_entry;
    entry_t           rd_entry;
    entry_t           wr_entry;
    entry_t           rsp_entry;
    logic [IDX_W-1:0] ram_raddr;
    logic [IDX_W-1:0] ram_waddr;
    logic             ram_we;
    logic [ENTRY_W-1:0] ram_rdata;

    mhf_hash u_hash (
        .low_part  (cmd_mac[31:0]),
        .high_bit7 (cmd_mac[39]),
        .home_idx  (home_idx)
    );

    mhf_encode u_encode (
        .mac   (cmd_mac),
        .skip  (cmd_skip),
        .rd    (cmd_rd),
        .entry (key_entry)
    );

    mhf_ram #(
        .AW (IDX_W),
        .DW (ENTRY_W)
    ) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .waddr (ram_waddr),
        .wdata (wr_entry),
        .raddr (ram_raddr),
        .rdata (ram_rdata)
    );

    assign rd_entry = entry_t'(ram_rdata);

    mhf_probe_ctrl #(
        .HOP_LIMIT (HOP_LIMIT)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .key_idx   (home_idx),
        .key_entry (key_entry),
        .rd_entry  (rd_entry),
        .ram_raddr (ram_raddr),
        .ram_we    (ram_we),
        .ram_waddr (ram_waddr),
        .ram_wdata (wr_entry),
        .busy      (busy),
        .done      (done),
        .rsp_hit   (rsp_hit),
        .rsp_full  (rsp_full),
        .rsp_index (rsp_index),
        .rsp_entry (rsp_entry)
    );

    assign rsp_lo = rsp_entry.lo;
    assign rsp_hi = rsp_entry.hi;
endmodule

// File: tb/mac_hash_filter_tb_top.sv
module mac_hash_filter_tb_top;
    localparam int HOPS  = 12;
    localparam int NSLOT = 2048;
    localparam int POOL  = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'd0;
    logic [47:0] cmd_mac = '0;
    logic        cmd_skip = 1'b0;
    logic        cmd_rd = 1'b0;
    logic        busy, done, rsp_hit, rsp_full;
    logic [10:0] rsp_index;
    logic [31:0] rsp_lo, rsp_hi;

    mac_hash_filter #(.HOP_LIMIT(HOPS)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_mac(cmd_mac), .cmd_skip(cmd_skip), .cmd_rd(cmd_rd),
        .busy(busy), .done(done), .rsp_hit(rsp_hit), .rsp_full(rsp_full),
        .rsp_index(rsp_index), .rsp_lo(rsp_lo), .rsp_hi(rsp_hi)
    );

    always #5 clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;

    logic [31:0] m_lo [NSLOT];
    logic [31:0] m_hi [NSLOT];

    logic        r_hit, r_full;
    logic [10:0] r_idx;
    logic [31:0] r_lo, r_hi;

    task automatic check(input string req, input logic [79:0] act,
                         input logic [79:0] exp, input string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [10:0] ref_hash(input logic [47:0] mac);
        logic [31:0] l;
        logic [5:0]  f0;
        logic [8:0]  f1, f2, f3;
        logic [31:0] t;
        for (int b = 0; b < 4; b++)
            for (int k = 0; k < 8; k++)
                l[8*b + k] = mac[8*b + 7 - k];
        f0 = l[7:2];
        f1 = {l[14:8], l[1:0]};
        f2 = l[23:15];
        f3 = {mac[39], l[31:24]};
        t  = (32'(f0) << 9) | 32'(f1 ^ f2 ^ f3);
        return t[10:0];
    endfunction

    function automatic logic [31:0] ref_lo(input logic [47:0] mac, input logic skip,
                                           input logic rd);
        return {mac[20], mac[19:16], mac[31:28], mac[27:24], mac[39:36], mac[35:32],
                mac[47:44], mac[43:40], rd, skip, 1'b1};
    endfunction

    function automatic logic [31:0] ref_hi(input logic [47:0] mac);
        return {13'd0, mac[7:4], mac[3:0], mac[15:12], mac[11:8], mac[23:21]};
    endfunction

    task automatic model_cmd(input logic [1:0] op, input logic [47:0] mac,
                             input logic skip, input logic rd,
                             output logic e_hit, output logic e_full,
                             output logic [10:0] e_idx, output logic [31:0] e_lo,
                             output logic [31:0] e_hi);
        logic [31:0] klo, khi;
        logic [10:0] p;
        logic        v, m;
        e_hit = 0; e_full = 0; e_idx = '0; e_lo = '0; e_hi = '0;
        if (op == 2'd3) begin
            for (int i = 0; i < NSLOT; i++) begin m_lo[i] = '0; m_hi[i] = '0; end
            return;
        end
        klo = ref_lo(mac, skip, rd);
        khi = ref_hi(mac);
        p = ref_hash(mac);
        for (int n = 0; n < HOPS; n++) begin
            v = m_lo[p][0];
            m = v && (m_lo[p][31:3] == klo[31:3]) && (m_hi[p] == khi);
            if (m || !v || n == HOPS - 1) begin
                e_idx = p;
                e_hit = m;
                if (op == 2'd1) begin
                    if (m || !v) begin
                        m_lo[p] = klo; m_hi[p] = khi; e_lo = klo; e_hi = khi;
                    end else begin
                        e_full = 1'b1;
                    end
                end else if (op == 2'd2) begin
                    if (m) begin m_lo[p] = '0; m_hi[p] = '0; end
                end else if (m) begin
                    e_lo = m_lo[p]; e_hi = m_hi[p];
                end
                break;
            end
            p = p + 11'd1;
        end
    endtask

    task automatic issue(input logic [1:0] op, input logic [47:0] mac,
                         input logic skip, input logic rd);
        int w;
        while (busy) @(negedge clk);
        cmd_op = op; cmd_mac = mac; cmd_skip = skip; cmd_rd = rd;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        w = 0;
        while (!done && w < 10000) begin @(negedge clk); w++; end
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL R11 no done pulse: actual 0 expected 1");
        end
        r_hit = rsp_hit; r_full = rsp_full; r_idx = rsp_index;
        r_lo = rsp_lo; r_hi = rsp_hi;
        @(negedge clk);
        check("R11", {78'd0, done, busy}, 80'd0, "done one cycle then idle");
    endtask

    task automatic run_cmd(input logic [1:0] op, input logic [47:0] mac,
                           input logic skip, input logic rd, input string req);
        logic e_hit, e_full;
        logic [10:0] e_idx;
        logic [31:0] e_lo, e_hi;
        model_cmd(op, mac, skip, rd, e_hit, e_full, e_idx, e_lo, e_hi);
        issue(op, mac, skip, rd);
        check(req, {3'd0, r_hit, r_full, r_idx, r_hi, r_lo},
                   {3'd0, e_hit, e_full, e_idx, e_hi, e_lo}, "response");
    endtask

    function automatic logic [47:0] find_base(input logic [10:0] target);
        logic [47:0] mac;
        for (int i = 0; i < 65536; i++) begin
            mac = {16'h2200, 16'h0000, 16'(i)};
            if (ref_hash(mac) == target) return mac;
        end
        return '0;
    endfunction

    // watchdog
    initial begin
        repeat (190000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [47:0] a_mac, b_mac, base, xmac;
        logic [47:0] grp [13];
        logic [47:0] pool [POOL];
        logic [10:0] h;
        int          cnt, nclr;

        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < NSLOT; i++) begin m_lo[i] = '0; m_hi[i] = '0; end

        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1", {66'd0, busy, done, rsp_hit, rsp_full, rsp_index}, 80'd0, "during reset");
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", {3'd0, busy, done, rsp_index, rsp_hi, rsp_lo}, 80'd0, "after reset");
        check("R1", {78'd0, rsp_hit, rsp_full}, 80'd0, "flags after reset");

        // R10: clear-all, then R2/R9 on a single entry
        run_cmd(2'd3, 48'h0, 1'b0, 1'b0, "R10");
        a_mac = 48'h02_1A_4B_7C_8D_9E;
        run_cmd(2'd1, a_mac, 1'b1, 1'b0, "R5");
        check("R2", {69'd0, r_idx}, {69'd0, ref_hash(a_mac)}, "home index of add");
        check("R9", {16'd0, r_hi, r_lo}, {16'd0, ref_hi(a_mac), ref_lo(a_mac, 1'b1, 1'b0)},
              "written entry");
        b_mac = 48'hF0_0D_C0_DE_55_AA;
        run_cmd(2'd1, b_mac, 1'b0, 1'b1, "R2");
        check("R2", {69'd0, r_idx}, {69'd0, ref_hash(b_mac)}, "home index second add");
        run_cmd(2'd0, a_mac, 1'b0, 1'b0, "R8");
        check("R9", {16'd0, r_hi, r_lo}, {16'd0, ref_hi(a_mac), ref_lo(a_mac, 1'b1, 1'b0)},
              "stored entry on lookup");

        // R3/R6: a colliding group shares one home index
        run_cmd(2'd3, 48'h0, 1'b0, 1'b0, "R10");
        base = 48'h00_5A_C3_17_9E_42;
        h = ref_hash(base);
        for (int i = 0; i < 13; i++) grp[i] = {8'(8'h40 + i), base[39:0]};
        for (int i = 0; i < 12; i++) begin
            run_cmd(2'd1, grp[i], 1'b0, 1'b0, "R3");
            check("R3", {69'd0, r_idx}, {69'd0, h + 11'(i)}, "consecutive slot");
        end
        run_cmd(2'd1, grp[12], 1'b0, 1'b0, "R6");
        check("R6", {78'd0, r_full, r_hit}, {78'd0, 2'b10}, "full flag");
        run_cmd(2'd0, grp[12], 1'b0, 1'b0, "R6");
        check("R6", {79'd0, r_hit}, 80'd0, "full add wrote nothing");

        // R5: re-add updates attributes in place
        run_cmd(2'd1, grp[3], 1'b1, 1'b1, "R5");
        check("R5", {68'd0, r_hit, r_idx}, {68'd0, 1'b1, h + 11'd3}, "re-add reuses slot");
        run_cmd(2'd0, grp[3], 1'b0, 1'b0, "R5");
        check("R5", {77'd0, r_lo[2:0]}, {77'd0, 3'b111}, "attributes replaced");

        // R7/R8: delete, repeated delete, and a lookup past the hole
        run_cmd(2'd2, grp[5], 1'b0, 1'b0, "R7");
        check("R7", {79'd0, r_hit}, 80'd1, "delete hit");
        run_cmd(2'd0, grp[5], 1'b0, 1'b0, "R7");
        check("R7", {79'd0, r_hit}, 80'd0, "deleted entry gone");
        run_cmd(2'd2, grp[5], 1'b0, 1'b0, "R7");
        check("R7", {78'd0, r_hit, r_full}, 80'd0, "delete of absent address");
        run_cmd(2'd0, grp[7], 1'b0, 1'b0, "R8");
        check("R8", {79'd0, r_hit}, 80'd0, "lookup stops at hole");

        // R4: wrap from 0x7FF to 0x000
        run_cmd(2'd3, 48'h0, 1'b0, 1'b0, "R10");
        base = find_base(11'h7FD);
        for (int i = 0; i < 5; i++) begin
            run_cmd(2'd1, {8'(8'h30 + i), base[39:0]}, 1'b0, 1'b1, "R4");
            check("R4", {69'd0, r_idx}, {69'd0, 11'h7FD + 11'(i)}, "wrapped slot");
        end
        run_cmd(2'd0, {8'h34, base[39:0]}, 1'b0, 1'b0, "R4");
        check("R4", {68'd0, r_hit, r_idx}, {68'd0, 1'b1, 11'h001}, "lookup across wrap");

        // R10/R11: clear span and commands ignored while busy
        xmac = 48'h77_66_55_44_33_22;
        while (busy) @(negedge clk);
        cmd_op = 2'd3; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_op = 2'd1; cmd_mac = xmac; cmd_valid = 1'b1;
        cnt = 0;
        for (int w = 0; w < 5000; w++) begin
            if (busy) cnt++;
            if (done) break;
            if (cnt == 3) cmd_valid = 1'b0;
            @(negedge clk);
        end
        cmd_valid = 1'b0;
        for (int i = 0; i < NSLOT; i++) begin m_lo[i] = '0; m_hi[i] = '0; end
        check("R10", 80'(cnt), 80'(NSLOT + 1), "clear busy cycles");
        @(negedge clk);
        run_cmd(2'd0, xmac, 1'b0, 1'b0, "R11");
        check("R11", {79'd0, r_hit}, 80'd0, "add during busy ignored");
        run_cmd(2'd0, grp[0], 1'b0, 1'b0, "R10");
        check("R10", {79'd0, r_hit}, 80'd0, "cleared entry invalid");

        // constrained random mix over a pool with heavy collisions
        base = {16'h0, $urandom()};
        for (int i = 0; i < 8; i++) pool[i] = {8'(8'h80 + i), base[39:0]};
        for (int i = 8; i < POOL; i++) pool[i] = {16'($urandom()), 32'($urandom())};
        nclr = 0;
        for (int it = 0; it < 350; it++) begin
            int r;
            logic [47:0] m;
            r = int'($urandom() % 100);
            m = pool[$urandom() % POOL];
            if (r < 3 && nclr < 4) begin
                nclr++;
                run_cmd(2'd3, m, 1'b0, 1'b0, "R10");
            end else if (r < 48) begin
                run_cmd(2'd1, m, 1'($urandom()), 1'($urandom()), "R5");
            end else if (r < 70) begin
                run_cmd(2'd2, m, 1'b0, 1'b0, "R7");
            end else begin
                run_cmd(2'd0, m, 1'b0, 1'b0, "R8");
            end
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule